// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 64-bit integer register file and a little-endian, byte-addressed data port with a 64-bit data path. It adds a signed 32-bit displacement to a 64-bit base value to form the effective address. It checks that the access is naturally aligned for its size. It then issues a single registered request on the memory port. For a store, the request carries the source bytes moved onto their byte lanes and a byte-enable mask. For a load, the unit waits for the response, picks out the addressed bytes and extends them to a 64-bit result.

Four access widths are supported: 1, 2, 4 and 8 bytes. Byte and 16-bit loads are zero-extended. 32-bit loads are sign-extended. A separate unaligned-quadword mode never faults: it clears the three low address bits and always moves eight bytes. Only one load may be outstanding at a time. While a load waits for its data, the unit reports itself busy and drops any new request.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended from 32 to 64 bits. A request accepted at a clock edge drives `mem_req_valid` high for exactly one cycle after that edge. During that cycle `mem_req_addr` equals the effective address with bits 2:0 cleared, and `mem_req_write` equals `req_is_store`.
- R2: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. In normal mode, an access whose effective address ANDed with (bytes-1) is non-zero raises `misalign` for one cycle after the accepting edge. No memory request is issued for it, and no load is started.
- R3: A 1-byte access is never misaligned, at any address.
- R4: On a store, `mem_req_strb` bit i is set exactly for the lanes from address bits 2:0 up to that value plus bytes-1. Lane i of `mem_req_wdata` (bits 8i+7:8i) carries source byte (i - addr[2:0]). Lanes that are not enabled are zero. Only the low 1, 2, 4 or 8 bytes of `req_store_data` are used.
- R5: 1-byte and 2-byte loads return the addressed bytes, little-endian, zero-extended to 64 bits.
- R6: 4-byte loads return the addressed bytes sign-extended from bit 31.
- R7: 8-byte loads return all eight lanes unchanged, with lane 0 in bits 7:0.
- R8: When `req_uq` is high, `req_size` is ignored. The low three address bits are cleared, `misalign` never rises, `mem_req_strb` is 8'hFF and the access moves eight bytes.
- R9: `ld_valid` pulses for one cycle, one cycle after `mem_rsp_valid` is seen with a load pending. The pulse carries `ld_data` and the destination tag captured with the request on `ld_dst`. On a load request `mem_req_wdata` is zero and `mem_req_strb` marks the lanes read.
- R10: `busy` is high from the cycle after a load is accepted up to, but not including, the cycle in which `ld_valid` is high. A request presented while `busy` is high is dropped: it causes no memory request, no `misalign` and no load.
- R11: During synchronous active-low reset, `mem_req_valid`, `misalign`, `ld_valid` and `busy` are all low in the cycle after the reset edge.
- R12: A `mem_rsp_valid` pulse while no load is pending produces no `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (0..3 = 1,2,4,8 bytes) |
| req_uq | input | 1 | Unaligned-quadword mode |
| req_base | input | 64 | Base register value |
| req_offset | input | 32 | Signed displacement |
| req_store_data | input | 64 | Store source register value |
| req_dst | input | 5 | Destination register tag for loads |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 64 | 8-byte-aligned memory address |
| mem_req_wdata | output | 64 | Lane-placed store data |
| mem_req_strb | output | 8 | Byte-lane enables |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 64 | Read data, 8 lanes |
| misalign | output | 1 | Misaligned access pulse |
| busy | output | 1 | Load outstanding |
| ld_valid | output | 1 | Load result strobe |
| ld_dst | output | 5 | Destination tag of the result |
| ld_data | output | 64 | Extended load result |

## Verification
A wrong lane shift or a bad mask in the store path shows up on `mem_req_wdata` and `mem_req_strb` in the very cycle after the accepting edge, so it is caught on the request itself. A corrupted pending size, lane or sign setting stays hidden until the response comes back. It then appears as a wrong `ld_data` two edges after the load was accepted, with the default response latency. A stuck or early-clearing pending flag shows at once as a `busy` mismatch. It also shows later as a dropped or extra `ld_valid`, and as requests that are swallowed or let through.

// File: rtl/lsu_pkg.sv
// Shared types and helpers for the load/store alignment unit.
// Assumes a 64-bit data path split into eight byte lanes.
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_QUAD = 2'd3
    } lsu_size_e;

    // Byte-count minus one for a width code, used as the alignment mask.
    function automatic logic [2:0] size_mask(input lsu_size_e sz);
        case (sz)
            SZ_BYTE: size_mask = 3'd0;
            SZ_HALF: size_mask = 3'd1;
            SZ_WORD: size_mask = 3'd3;
            default: size_mask = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
// Effective-address and alignment stage.
// Adds the sign-extended displacement to the base, applies the
// unaligned-quadword override and flags natural-alignment faults.
// Purely combinational; the caller registers its outputs.
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 32,
    parameter int LANE_W = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size_in,
    input  logic              uq_mode,
    output logic [ADDR_W-1:0] line_addr,
    output logic [LANE_W-1:0] lane,
    output lsu_size_e         eff_size,
    output logic              bad_align
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] sum;
    logic [2:0]        amask;

    // Form the raw effective address with a sign-extended displacement.
    always_comb begin
        sum = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    end

    // Choose the width actually used and the lane of the first byte.
    always_comb begin
        eff_size = uq_mode ? SZ_QUAD : lsu_size_e'(size_in);
        lane     = uq_mode ? '0 : sum[LANE_W-1:0];
    end

    // Test the low address bits against the width mask; quadword override never faults.
    always_comb begin
        amask     = size_mask(eff_size);
        bad_align = !uq_mode && ((sum[2:0] & amask) != 3'd0);
    end

    // Present the address of the 8-byte line holding the access.
    always_comb begin
        line_addr = {sum[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    end

endmodule

// File: rtl/lsu_store_lanes.sv
// Store lane placement.
// Keeps the low bytes of the source that the width selects, moves them
// up to the starting lane and builds the matching byte-enable mask.
// Assumes an aligned access, so the shifted bytes never leave the line.
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 3
) (
    input  logic [DATA_W-1:0]   src,
    input  lsu_size_e           size,
    input  logic [LANE_W-1:0]   lane,
    input  logic                is_store,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] strb
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0]  base_en;
    logic [DATA_W-1:0] keep;

    // Per-lane enable before shifting: lane i is used when i <= bytes-1.
    for (genvar i = 0; i < LANES; i++) begin : g_en
        always_comb begin
            base_en[i] = (i <= int'(size_mask(size)));
        end
        // Expand each byte enable into a bit mask for the source word.
        always_comb begin
            keep[i*8 +: 8] = {8{base_en[i]}};
        end
    end

    // Shift mask and trimmed data up to the starting lane; loads carry no data.
    always_comb begin
        strb  = base_en << lane;
        wdata = is_store ? ((src & keep) << {lane, 3'b000}) : '0;
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Load result formation.
// Moves the addressed lanes down to bit 0 and widens them: 1- and 2-byte
// results are zero-filled, 4-byte results copy bit 31, 8-byte pass through.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 3
) (
    input  logic [DATA_W-1:0] rdata,
    input  lsu_size_e         size,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] low;

    // Bring the first addressed byte down to lane 0.
    always_comb begin
        low = rdata >> {lane, 3'b000};
    end

    // Widen the selected bytes according to the access width.
    always_comb begin
        case (size)
            SZ_BYTE: result = {{(DATA_W-8){1'b0}},  low[7:0]};
            SZ_HALF: result = {{(DATA_W-16){1'b0}}, low[15:0]};
            SZ_WORD: result = {{(DATA_W-32){low[31]}}, low[31:0]};
            default: result = low;
        endcase
    end

endmodule

// File: rtl/lsu_align_unit.sv
// Load/store data alignment unit (top).
// Registers one memory request per accepted access, or a misalign pulse
// instead of it. Tracks a single outstanding load and returns its widened
// result one cycle after the response. Requests that arrive while a load
// is outstanding are dropped; the issuer is expected to watch busy.
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 32,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [1:0]        req_size,
    input  logic              req_uq,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_store_data,
    input  logic [TAG_W-1:0]  req_dst,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [7:0]        mem_req_strb,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              misalign,
    output logic              busy,
    output logic              ld_valid,
    output logic [TAG_W-1:0]  ld_dst,
    output logic [DATA_W-1:0] ld_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [ADDR_W-1:0] ag_addr;
    logic [LANE_W-1:0] ag_lane;
    lsu_size_e         ag_size;
    logic              ag_bad;
    logic [DATA_W-1:0] st_wdata;
    logic [LANES-1:0]  st_strb;
    logic [DATA_W-1:0] ld_result;

    logic              accept;
    logic              pend_q;
    lsu_size_e         pend_size_q;
    logic [LANE_W-1:0] pend_lane_q;
    logic [TAG_W-1:0]  pend_dst_q;

    lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_agen (
        .base      (req_base),
        .offset    (req_offset),
        .size_in   (req_size),
        .uq_mode   (req_uq),
        .line_addr (ag_addr),
        .lane      (ag_lane),
        .eff_size  (ag_size),
        .bad_align (ag_bad)
    );

    lsu_store_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_slane (
        .src      (req_store_data),
        .size     (ag_size),
        .lane     (ag_lane),
        .is_store (req_is_store),
        .wdata    (st_wdata),
        .strb     (st_strb)
    );

    lsu_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lext (
        .rdata  (mem_rsp_rdata),
        .size   (pend_size_q),
        .lane   (pend_lane_q),
        .result (ld_result)
    );

    // A request is taken only when no load is outstanding.
    always_comb begin
        accept = req_valid && !pend_q;
    end

    // Request stage: one-cycle request or misalign pulse per accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
            mem_req_strb  <= '0;
            misalign      <= 1'b0;
        end else begin
            mem_req_valid <= accept && !ag_bad;
            misalign      <= accept && ag_bad;
            if (accept && !ag_bad) begin
                mem_req_write <= req_is_store;
                mem_req_addr  <= ag_addr;
                mem_req_wdata <= st_wdata;
                mem_req_strb  <= st_strb;
            end
        end
    end

    // Pending-load tracker: set on an issued load, cleared by its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_size_q <= SZ_BYTE;
            pend_lane_q <= '0;
            pend_dst_q  <= '0;
        end else if (accept && !ag_bad && !req_is_store) begin
            pend_q      <= 1'b1;
            pend_size_q <= ag_size;
            pend_lane_q <= ag_lane;
            pend_dst_q  <= req_dst;
        end else if (pend_q && mem_rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    // Result stage: register the widened data one cycle after the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_dst   <= '0;
            ld_data  <= '0;
        end else begin
            ld_valid <= pend_q && mem_rsp_valid;
            if (pend_q && mem_rsp_valid) begin
                ld_dst  <= pend_dst_q;
                ld_data <= ld_result;
            end
        end
    end

    // Expose the outstanding-load state.
    always_comb begin
        busy = pend_q;
    end

endmodule

// File: rtl/lsu_align_unit_chk.sv
// Protocol checker for lsu_align_unit, attached by bind.
// Observes ports only; relations between request, response and result.
module lsu_align_unit_chk #(
    parameter int TAG_W = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_uq,
    input logic       mem_req_valid,
    input logic       mem_req_write,
    input logic [7:0] mem_req_strb,
    input logic       mem_rsp_valid,
    input logic       misalign,
    input logic       busy,
    input logic       ld_valid
);
    // R2
    misalign_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(misalign && mem_req_valid));

    // R10
    req_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || misalign) |-> $past(req_valid && !busy));

    // R4
    store_strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |->
        ($countones(mem_req_strb) == 1 || $countones(mem_req_strb) == 2 ||
         $countones(mem_req_strb) == 4 || $countones(mem_req_strb) == 8));

    // R8
    uq_full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(req_uq)) |-> (mem_req_strb == 8'hFF));

    // R9
    result_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($past(mem_rsp_valid) && $past(busy)));

    // R10
    result_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !busy);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req_valid && !misalign && !ld_valid && !busy));

endmodule

bind lsu_align_unit lsu_align_unit_chk #(.TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_uq        (req_uq),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_strb  (mem_req_strb),
    .mem_rsp_valid (mem_rsp_valid),
    .misalign      (misalign),
    .busy          (busy),
    .ld_valid      (ld_valid)
);

// File: tb/tb_lsu_align_unit.sv
// Bench for lsu_align_unit: behavioural byte memory plus a cycle model
// compared against every output on each falling edge.
module tb_lsu_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_uq = 1'b0;
    logic [63:0] req_base = '0;
    logic [31:0] req_offset = '0;
    logic [63:0] req_store_data = '0;
    logic [4:0]  req_dst = '0;
    logic        mem_req_valid, mem_req_write;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic [7:0]  mem_req_strb;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        misalign, busy, ld_valid;
    logic [4:0]  ld_dst;
    logic [63:0] ld_data;

    lsu_align_unit dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem_bytes [longint unsigned];

    function automatic logic [7:0] rd_byte(input logic [63:0] a);
        if (mem_bytes.exists(a)) return mem_bytes[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_busy = 0;
    int          ld_cnt = 0;
    bit          e_mreq = 0, e_mis = 0, e_ldv = 0, e_wr = 0;
    logic [63:0] e_addr = '0, e_wd = '0, e_ldd = '0, p_data = '0;
    logic [7:0]  e_strb = '0;
    logic [4:0]  e_dst = '0, p_dst = '0;
    string       req_tag = "R1", ld_tag = "R9", p_tag = "R7";
    string       rsp_tag = "R9";
    bit          in_reset = 1;

    always @(posedge clk) begin
        bit was_busy;
        logic [63:0] ea;
        int n;
        if (!rst_n) begin
            m_busy = 0; ld_cnt = 0; e_mreq = 0; e_mis = 0; e_ldv = 0;
        end else begin
            e_mreq = 0; e_mis = 0; e_ldv = 0;
            was_busy = m_busy;
            if (ld_cnt > 0) begin
                ld_cnt--;
                if (ld_cnt == 0) begin
                    e_ldv = 1; e_ldd = p_data; e_dst = p_dst; ld_tag = p_tag; m_busy = 0;
                end
            end
            if (req_valid && !was_busy) begin
                ea = req_base + {{32{req_offset[31]}}, req_offset};
                n = 1 << req_size;
                req_tag = (req_size == 2'd0) ? "R3" : "R1";
                if (req_uq) begin ea[2:0] = 3'b000; n = 8; req_tag = "R8"; end
                if (!req_uq && (ea % n) != 0) begin
                    e_mis = 1; req_tag = "R2";
                end else begin
                    e_mreq = 1; e_wr = req_is_store;
                    e_addr = {ea[63:3], 3'b000};
                    e_strb = '0; e_wd = '0;
                    for (int i = 0; i < n; i++) begin
                        e_strb[ea[2:0] + i] = 1'b1;
                        if (req_is_store) e_wd[(ea[2:0] + i)*8 +: 8] = req_store_data[i*8 +: 8];
                    end
                    if (req_is_store && !req_uq) req_tag = "R4";
                    if (!req_is_store) begin
                        p_data = '0;
                        for (int i = 0; i < n; i++) p_data[i*8 +: 8] = rd_byte(ea + 64'(i));
                        if (n == 4) p_data[63:32] = {32{p_data[31]}};
                        p_dst = req_dst;
                        p_tag = req_uq ? "R8" : (n == 4) ? "R6" : (n == 8) ? "R7" : "R5";
                        m_busy = 1; ld_cnt = 2;
                    end
                end
            end
        end
    end

    // ---------------- compare on every falling edge ----------------
    always @(negedge clk) begin
        string t;
        t = in_reset ? "R11" : req_tag;
        chk(mem_req_valid == e_mreq, t, "mem_req_valid", 64'(mem_req_valid), 64'(e_mreq));
        chk(misalign == e_mis, in_reset ? "R11" : "R2", "misalign", 64'(misalign), 64'(e_mis));
        chk(busy == m_busy, in_reset ? "R11" : "R10", "busy", 64'(busy), 64'(m_busy));
        chk(ld_valid == e_ldv, in_reset ? "R11" : rsp_tag, "ld_valid", 64'(ld_valid), 64'(e_ldv));
        if (e_mreq && mem_req_valid) begin
            chk(mem_req_addr == e_addr, t, "mem_req_addr", mem_req_addr, e_addr);
            chk(mem_req_write == e_wr, "R1", "mem_req_write", 64'(mem_req_write), 64'(e_wr));
            chk(mem_req_strb == e_strb, t, "mem_req_strb", 64'(mem_req_strb), 64'(e_strb));
            chk(mem_req_wdata == e_wd, e_wr ? t : "R9", "mem_req_wdata", mem_req_wdata, e_wd);
        end
        if (e_ldv && ld_valid) begin
            chk(ld_data == e_ldd, ld_tag, "ld_data", ld_data, e_ldd);
            chk(ld_dst == e_dst, "R9", "ld_dst", 64'(ld_dst), 64'(e_dst));
        end
    end

    // ---------------- memory responder ----------------
    int          rsp_cnt = 0;
    logic [63:0] rsp_addr = '0;
    bit          stray_req = 0;

    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_rdata <= {$urandom, $urandom};
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                logic [63:0] d;
                for (int i = 0; i < 8; i++) d[i*8 +: 8] = rd_byte(rsp_addr + 64'(i));
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= d;
            end
        end else if (stray_req) begin
            mem_rsp_valid <= 1'b1;
            stray_req = 0;
        end
        if (rst_n && mem_req_valid) begin
            if (mem_req_write) begin
                for (int i = 0; i < 8; i++)
                    if (mem_req_strb[i]) mem_bytes[mem_req_addr + 64'(i)] = mem_req_wdata[i*8 +: 8];
            end else begin
                rsp_cnt = 1; rsp_addr = mem_req_addr;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit st, input logic [1:0] sz, input bit uq,
                         input logic [63:0] b, input logic [31:0] off,
                         input logic [63:0] sd, input logic [4:0] dst, input int gap);
        @(negedge clk);
        req_valid = 1; req_is_store = st; req_size = sz; req_uq = uq;
        req_base = b; req_offset = off; req_store_data = sd; req_dst = dst;
        @(negedge clk);
        req_valid = 0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        in_reset = 0;
        // R4: stores of each width at several lanes
        issue(1, 2'd3, 0, 64'h1000, 32'd0, 64'h8877_6655_4433_2211, 0, 2);
        issue(1, 2'd2, 0, 64'h1010, 32'd4, 64'hDEAD_BEEF_8000_0001, 0, 2);
        issue(1, 2'd1, 0, 64'h1018, 32'd6, 64'hFFFF_FFFF_FFFF_9ABC, 0, 2);
        issue(1, 2'd0, 0, 64'h1020, 32'd3, 64'h0000_0000_0000_0080, 0, 2);
        issue(1, 2'd2, 0, 64'h1028, 32'd0, 64'h0000_0000_1234_5678, 0, 2);
        // R5 R6 R7: loads back, zero and sign extension
        issue(0, 2'd3, 0, 64'h1000, 32'd0, '0, 5'd1, 4);
        issue(0, 2'd2, 0, 64'h1010, 32'd4, '0, 5'd2, 4);
        issue(0, 2'd2, 0, 64'h1028, 32'd0, '0, 5'd3, 4);
        issue(0, 2'd1, 0, 64'h1018, 32'd6, '0, 5'd4, 4);
        issue(0, 2'd0, 0, 64'h1020, 32'd3, '0, 5'd5, 4);
        // R1: negative displacement
        issue(0, 2'd1, 0, 64'h1020, 32'hFFFF_FFF8, '0, 5'd6, 4);
        // R2: misaligned in normal mode; R3: odd byte address
        issue(0, 2'd1, 0, 64'h2001, 32'd0, '0, 5'd7, 2);
        issue(1, 2'd2, 0, 64'h2002, 32'd0, 64'h1, 0, 2);
        issue(0, 2'd3, 0, 64'h2000, 32'd4, '0, 5'd8, 2);
        issue(0, 2'd0, 0, 64'h2007, 32'd0, '0, 5'd9, 4);
        // R8: unaligned-quadword mode, size field ignored
        issue(1, 2'd0, 1, 64'h3005, 32'd0, 64'h0102_0304_0506_0708, 0, 2);
        issue(0, 2'd1, 1, 64'h3003, 32'd0, '0, 5'd10, 4);
        // R10: back-to-back requests while busy are dropped
        issue(0, 2'd3, 0, 64'h1000, 32'd0, '0, 5'd11, 0);
        issue(1, 2'd3, 0, 64'h1000, 32'd0, 64'hFFFF, 0, 0);
        issue(0, 2'd1, 0, 64'h1001, 32'd0, '0, 5'd12, 4);
        issue(0, 2'd3, 0, 64'h1000, 32'd0, '0, 5'd13, 4);
        // R12: stray response with nothing pending
        rsp_tag = "R12";
        @(negedge clk); stray_req = 1;
        repeat (4) @(negedge clk);
        rsp_tag = "R9";
        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            issue($urandom_range(0, 1), 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
                  64'h4000 + 64'($urandom_range(0, 63)), 32'($signed($urandom_range(0, 31)) - 16),
                  {$urandom, $urandom}, 5'($urandom), $urandom_range(0, 3));
        end
        repeat (6) @(negedge clk);
        // R11: reset in the middle of a load
        issue(0, 2'd3, 0, 64'h1000, 32'd0, '0, 5'd14, 0);
        in_reset = 1; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        in_reset = 0;
        issue(0, 2'd2, 0, 64'h1010, 32'd4, '0, 5'd15, 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule